// File: doc/BRIEF.md
# Register File Self-Test Sequencer

This block runs a built-in self-test on a multi-ported register file that sits beside it. On a start request it drives every write port with a data word, a load strobe and a register index. It also drives every read port with a load strobe and a register index. All of these follow a fixed schedule that is computed at elaboration from the register count, the port counts, the per-cycle write limit and the read latency. Every register is written once with a pseudo-random word. A shadow copy of each write is kept inside the block. Each register is then read back and compared with the shadow copy.

Writing and reading overlap. Read requests start as soon as the read sweep can run without stalling behind the writes. Comparison starts once the read latency has elapsed. At the end of the run the block raises done. It reports a pass flag and the schedule cycle of the first mismatch. A lock input freezes the whole sequence for as long as it is held.

Top module: `rfbist_seq`

## Requirements
- R1: During and after reset, every write load, write data, write index, read load and read index output is 0, and busy, done, pass and fail_cycle are 0.
- R2: A start sampled high while idle and unlocked begins a run. The outputs for schedule cycle 0 appear after that clock edge, and busy stays high for the whole run. A start sampled while a run is in progress has no effect on the schedule.
- R3: The schedule lengths are as follows.
  - FILL is ceil(NREG/NWR) when NREG >= NWR, and NREG otherwise.
  - SWEEP is ceil(NREG/NRD).
  - If FILL > SWEEP, the flush phase lasts LAT cycles and checking starts at cycle IGN = FILL + LAT - SWEEP.
  - Otherwise, the flush phase lasts LAT + SWEEP - FILL cycles and IGN = LAT.
  - TOTAL is FILL plus flush. Done rises TOTAL unlocked edges after the start edge, and busy falls at the same edge.
- R4: In a fill cycle (cycle < FILL), real writes go to write ports 0, 1, 2 and onward in ascending order. There are at most MAXWR of them per cycle, and they occur only while unwritten registers remain. Register indices rise by one per real write, starting from 0. Every other write port, and every port in the flush phase, shows load 0, data 0 and index 0.
- R5: Register r is written with the low DW bits of the LFSR state reached after r+1 steps from SEED. Each step is a right-shifting Galois LFSR update: shift right one place, then XOR with 32'hA3000000 if the bit shifted out was 1. SEED is reloaded at every start.
- R6: From cycle IGN-LAT through TOTAL-1, every read port is loaded. Read port j is given register (b+j) mod NREG, where b starts at 0 and advances by NRD mod NREG each cycle. Outside that window, read load and read index are 0.
- R7: In each cycle c >= IGN, read data on port j is compared with the shadow value of the register requested on that port in cycle c-LAT. The shadow value of a register is the last value written to it in a cycle before c. Registers never written in the run are expected to read 0.
- R8: Start sets pass to 1 and fail_cycle to 0. The first mismatch clears pass and records its schedule cycle number in fail_cycle. Both values, and done, are then held until the next start.
- R9: While lock is high, all outputs and all sequence progress hold still, and a start is ignored. When lock falls, the run resumes exactly where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run when idle |
| lock | input | 1 | Freeze the sequence while high |
| rd_data | input | NRD*DW | Data returned by the read ports, port j in bits j*DW upward |
| wr_data | output | NWR*DW | Write data per write port |
| wr_load | output | NWR | Write strobe per write port |
| wr_idx | output | NWR*IW | Target register per write port |
| rd_load | output | NRD | Read strobe per read port |
| rd_idx | output | NRD*IW | Requested register per read port |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed |
| pass | output | 1 | No mismatch seen in this run |
| fail_cycle | output | CW | Schedule cycle of the first mismatch |

## Verification
Every port value belonging to schedule cycle c is due one clock edge after the edge that ends cycle c-1. The scoreboard pops one expected item on each falling edge that follows an unlocked rising edge while busy is high, and skips locked edges. Read data is due LAT edges after its request, so the bench's register-file model registers its reply once, and mismatch cycles are predicted as IGN plus the sweep slot of the faulty register. Done is expected exactly TOTAL edges after the start edge, plus one edge for every locked edge in between.

// File: rtl/rfbist_pkg.sv
package rfbist_pkg;

  localparam logic [31:0] LFSR_TAPS = 32'hA300_0000;

  function automatic int div_up(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int fill_len(input int nreg, input int nwr);
    return (nreg >= nwr) ? div_up(nreg, nwr) : nreg;
  endfunction

  function automatic int sweep_len(input int nreg, input int nrd);
    return div_up(nreg, nrd);
  endfunction

  function automatic int flush_len(input int nreg, input int nwr, input int nrd, input int lat);
    int f = fill_len(nreg, nwr);
    int r = sweep_len(nreg, nrd);
    return (f > r) ? lat : lat + r - f;
  endfunction

  function automatic int skip_len(input int nreg, input int nwr, input int nrd, input int lat);
    int f = fill_len(nreg, nwr);
    int r = sweep_len(nreg, nrd);
    return (f > r) ? f + lat - r : lat;
  endfunction

  function automatic logic [31:0] lfsr_adv(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction

endpackage

// File: rtl/rfbist_ctrl.sv
module rfbist_ctrl #(
  parameter int TOTAL = 5,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          lock,
  output logic          fresh,
  output logic          step,
  output logic          ending,
  output logic          go_next,
  output logic [CW-1:0] cyc,
  output logic [CW-1:0] nxt_cyc,
  output logic          busy,
  output logic          done
);

  always_comb begin
    fresh   = !busy && start && !lock;
    step    = busy && !lock;
    ending  = step && (cyc == CW'(TOTAL - 1));
    go_next = fresh || (step && !ending);
    nxt_cyc = fresh ? '0 : cyc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cyc  <= '0;
    end else if (fresh) begin
      busy <= 1'b1;
      done <= 1'b0;
      cyc  <= '0;
    end else if (ending) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (step) begin
      cyc <= nxt_cyc;
    end
  end

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && lock) |=> (busy && $stable(cyc)));

  assert_cycle_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !lock && cyc != CW'(TOTAL - 1)) |=> (busy && cyc == $past(cyc) + 1'b1));

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!busy && $past(cyc) == CW'(TOTAL - 1)));

endmodule

// File: rtl/rfbist_wgen.sv
module rfbist_wgen
  import rfbist_pkg::*;
#(
  parameter int          NREG  = 8,
  parameter int          DW    = 16,
  parameter int          NWR   = 3,
  parameter int          MAXWR = 2,
  parameter int          IW    = 3,
  parameter int          CW    = 3,
  parameter int          FILL  = 3,
  parameter logic [31:0] SEED  = 32'h5EED_C0DE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fresh,
  input  logic              go_next,
  input  logic              ending,
  input  logic [CW-1:0]     nxt_cyc,
  output logic [NWR*DW-1:0] wr_data,
  output logic [NWR-1:0]    wr_load,
  output logic [NWR*IW-1:0] wr_idx
);

  localparam int BW  = $clog2(NREG + 1);
  localparam int NCW = $clog2(NWR + 1);

  logic [BW-1:0]     base_q, base_c;
  logic [31:0]       state_q;
  logic [31:0]       chain [NWR+1];
  logic [NWR-1:0]    real_c;
  logic [NWR*DW-1:0] data_c;
  logic [NWR*IW-1:0] idx_c;
  logic [NCW-1:0]    cnt_c;

  assign base_c   = fresh ? '0 : base_q;
  assign chain[0] = fresh ? SEED : state_q;

  generate
    for (genvar k = 1; k <= NWR; k++) begin : g_chain
      assign chain[k] = lfsr_adv(chain[k-1]);
    end
  endgenerate

  always_comb begin
    real_c = '0;
    data_c = '0;
    idx_c  = '0;
    cnt_c  = '0;
    for (int j = 0; j < NWR; j++) begin
      if (int'(nxt_cyc) < FILL && j < MAXWR && int'(base_c) + j < NREG) begin
        real_c[j]            = 1'b1;
        data_c[j*DW +: DW]   = chain[j+1][DW-1:0];
        idx_c[j*IW +: IW]    = IW'(int'(base_c) + j);
        cnt_c                = cnt_c + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_data <= '0;
      wr_load <= '0;
      wr_idx  <= '0;
      base_q  <= '0;
      state_q <= SEED;
    end else if (go_next) begin
      wr_data <= data_c;
      wr_load <= real_c;
      wr_idx  <= idx_c;
      base_q  <= base_c + BW'(cnt_c);
      state_q <= chain[cnt_c];
    end else if (ending) begin
      wr_data <= '0;
      wr_load <= '0;
      wr_idx  <= '0;
    end
  end

  assert_write_cap_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_load) <= MAXWR);

  generate
    for (genvar j = 1; j < NWR; j++) begin : g_order
      assert_write_order_R4: assert property (@(posedge clk) disable iff (rst)
        wr_load[j] |-> (wr_load[j-1] && wr_idx[j*IW +: IW] == wr_idx[(j-1)*IW +: IW] + 1'b1));
    end
  endgenerate

endmodule

// File: rtl/rfbist_rgen.sv
module rfbist_rgen #(
  parameter int NREG = 8,
  parameter int NRD  = 2,
  parameter int IW   = 3,
  parameter int CW   = 3,
  parameter int REQ0 = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fresh,
  input  logic              go_next,
  input  logic              ending,
  input  logic [CW-1:0]     nxt_cyc,
  output logic [NRD-1:0]    rd_load,
  output logic [NRD*IW-1:0] rd_idx
);

  logic [IW-1:0]     base_q, base_c;
  logic              active_c;
  logic [NRD*IW-1:0] idx_c;

  assign base_c = fresh ? '0 : base_q;

  always_comb begin
    active_c = int'(nxt_cyc) >= REQ0;
    idx_c    = '0;
    for (int j = 0; j < NRD; j++) begin
      if (active_c) idx_c[j*IW +: IW] = IW'((int'(base_c) + j) % NREG);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_load <= '0;
      rd_idx  <= '0;
      base_q  <= '0;
    end else if (go_next) begin
      rd_load <= {NRD{active_c}};
      rd_idx  <= idx_c;
      base_q  <= active_c ? IW'((int'(base_c) + NRD) % NREG) : base_c;
    end else if (ending) begin
      rd_load <= '0;
      rd_idx  <= '0;
    end
  end

  assert_read_all_ports_R6: assert property (@(posedge clk) disable iff (rst)
    (|rd_load) |-> (&rd_load));

  assert_read_index_range_R6: assert property (@(posedge clk) disable iff (rst)
    int'(rd_idx[IW-1:0]) < NREG);

endmodule

// File: rtl/rfbist_cmp.sv
module rfbist_cmp #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int NWR  = 3,
  parameter int NRD  = 2,
  parameter int IW   = 3,
  parameter int CW   = 3,
  parameter int IGN  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fresh,
  input  logic              step,
  input  logic [CW-1:0]     cyc,
  input  logic [NWR*DW-1:0] wr_data,
  input  logic [NWR-1:0]    wr_load,
  input  logic [NWR*IW-1:0] wr_idx,
  input  logic [NRD*DW-1:0] rd_data,
  output logic              pass,
  output logic [CW-1:0]     fail_cycle
);

  logic [DW-1:0]  shadow [NREG];
  logic [IW-1:0]  chk_q;
  logic           chk_c;
  logic [NRD-1:0] miss_c;

  always_comb begin
    chk_c  = step && int'(cyc) >= IGN;
    miss_c = '0;
    for (int j = 0; j < NRD; j++) begin
      miss_c[j] = chk_c && (rd_data[j*DW +: DW] != shadow[(int'(chk_q) + j) % NREG]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass       <= 1'b0;
      fail_cycle <= '0;
      chk_q      <= '0;
      for (int k = 0; k < NREG; k++) shadow[k] <= '0;
    end else if (fresh) begin
      pass       <= 1'b1;
      fail_cycle <= '0;
      chk_q      <= '0;
      for (int k = 0; k < NREG; k++) shadow[k] <= '0;
    end else if (step) begin
      for (int j = 0; j < NWR; j++) begin
        if (wr_load[j]) shadow[int'(wr_idx[j*IW +: IW]) % NREG] <= wr_data[j*DW +: DW];
      end
      if (chk_c) chk_q <= IW'((int'(chk_q) + NRD) % NREG);
      if ((|miss_c) && pass) begin
        pass       <= 1'b0;
        fail_cycle <= cyc;
      end
    end
  end

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!pass && !fresh) |=> !pass);

  assert_fail_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!pass && !fresh) |=> $stable(fail_cycle));

  assert_fail_window_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pass) |-> (int'(fail_cycle) >= IGN));

endmodule

// File: rtl/rfbist_seq.sv
module rfbist_seq
  import rfbist_pkg::*;
#(
  parameter int          NREG  = 8,
  parameter int          DW    = 16,
  parameter int          NWR   = 3,
  parameter int          NRD   = 2,
  parameter int          MAXWR = 2,
  parameter int          LAT   = 1,
  parameter logic [31:0] SEED  = 32'h5EED_C0DE,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int FILL  = fill_len(NREG, NWR),
  localparam int IGN   = skip_len(NREG, NWR, NRD, LAT),
  localparam int TOTAL = FILL + flush_len(NREG, NWR, NRD, LAT),
  localparam int REQ0  = IGN - LAT,
  localparam int CW    = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              lock,
  input  logic [NRD*DW-1:0] rd_data,
  output logic [NWR*DW-1:0] wr_data,
  output logic [NWR-1:0]    wr_load,
  output logic [NWR*IW-1:0] wr_idx,
  output logic [NRD-1:0]    rd_load,
  output logic [NRD*IW-1:0] rd_idx,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CW-1:0]     fail_cycle
);

  logic          fresh, step, ending, go_next;
  logic [CW-1:0] cyc, nxt_cyc;

  rfbist_ctrl #(.TOTAL(TOTAL), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .lock(lock),
    .fresh(fresh), .step(step), .ending(ending), .go_next(go_next),
    .cyc(cyc), .nxt_cyc(nxt_cyc), .busy(busy), .done(done)
  );

  rfbist_wgen #(
    .NREG(NREG), .DW(DW), .NWR(NWR), .MAXWR(MAXWR),
    .IW(IW), .CW(CW), .FILL(FILL), .SEED(SEED)
  ) u_wgen (
    .clk(clk), .rst(rst), .fresh(fresh), .go_next(go_next), .ending(ending),
    .nxt_cyc(nxt_cyc), .wr_data(wr_data), .wr_load(wr_load), .wr_idx(wr_idx)
  );

  rfbist_rgen #(
    .NREG(NREG), .NRD(NRD), .IW(IW), .CW(CW), .REQ0(REQ0)
  ) u_rgen (
    .clk(clk), .rst(rst), .fresh(fresh), .go_next(go_next), .ending(ending),
    .nxt_cyc(nxt_cyc), .rd_load(rd_load), .rd_idx(rd_idx)
  );

  rfbist_cmp #(
    .NREG(NREG), .DW(DW), .NWR(NWR), .NRD(NRD), .IW(IW), .CW(CW), .IGN(IGN)
  ) u_cmp (
    .clk(clk), .rst(rst), .fresh(fresh), .step(step), .cyc(cyc),
    .wr_data(wr_data), .wr_load(wr_load), .wr_idx(wr_idx), .rd_data(rd_data),
    .pass(pass), .fail_cycle(fail_cycle)
  );

  assert_ports_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (wr_load == '0 && rd_load == '0));

  assert_start_ignored_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !lock && !done) |=> (busy || done));

endmodule

// File: tb/test_rfbist_seq.sv
module test_rfbist_seq;

  localparam int          NREG  = 8;
  localparam int          DW    = 16;
  localparam int          NWR   = 3;
  localparam int          NRD   = 2;
  localparam int          MAXWR = 2;
  localparam int          LAT   = 1;
  localparam logic [31:0] SEED  = 32'h5EED_C0DE;
  localparam int          IW    = 3;
  localparam int          FILL  = (NREG >= NWR) ? (NREG + NWR - 1) / NWR : NREG;
  localparam int          SWEEP = (NREG + NRD - 1) / NRD;
  localparam int          IGN   = (FILL > SWEEP) ? FILL + LAT - SWEEP : LAT;
  localparam int          TOTAL = FILL + ((FILL > SWEEP) ? LAT : LAT + SWEEP - FILL);
  localparam int          CW    = $clog2(TOTAL + 1);

  typedef struct packed {
    logic [NWR*DW-1:0] wd;
    logic [NWR-1:0]    wl;
    logic [NWR*IW-1:0] wi;
    logic [NRD-1:0]    rl;
    logic [NRD*IW-1:0] ri;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              lock = 1'b0;
  logic [NRD*DW-1:0] rd_data;
  logic [NWR*DW-1:0] wr_data;
  logic [NWR-1:0]    wr_load;
  logic [NWR*IW-1:0] wr_idx;
  logic [NRD-1:0]    rd_load;
  logic [NRD*IW-1:0] rd_idx;
  logic              busy, done, pass;
  logic [CW-1:0]     fail_cycle;

  int    n_run = 0;
  int    n_fail = 0;
  item_t exp_q[$];
  item_t snap;
  logic  lk_q = 1'b0;
  bit    inject = 1'b0;
  int    fault_reg = 0;

  always #5 clk = ~clk;

  rfbist_seq #(
    .NREG(NREG), .DW(DW), .NWR(NWR), .NRD(NRD), .MAXWR(MAXWR), .LAT(LAT), .SEED(SEED)
  ) i_rfbist_seq (
    .clk(clk), .rst(rst), .start(start), .lock(lock), .rd_data(rd_data),
    .wr_data(wr_data), .wr_load(wr_load), .wr_idx(wr_idx),
    .rd_load(rd_load), .rd_idx(rd_idx),
    .busy(busy), .done(done), .pass(pass), .fail_cycle(fail_cycle)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'hA300_0000) : (s >> 1);
  endfunction

  // Register-file model: one cycle read latency, same-cycle write visible to a read.
  logic [DW-1:0] mem [NREG];
  always @(posedge clk) begin
    logic [DW-1:0] v;
    if (rst) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
      rd_data <= '0;
    end else if (!lock) begin
      for (int j = 0; j < NWR; j++)
        if (wr_load[j]) mem[wr_idx[j*IW +: IW]] <= wr_data[j*DW +: DW];
      for (int j = 0; j < NRD; j++) begin
        if (rd_load[j]) begin
          v = mem[rd_idx[j*IW +: IW]];
          for (int w = 0; w < NWR; w++)
            if (wr_load[w] && wr_idx[w*IW +: IW] == rd_idx[j*IW +: IW]) v = wr_data[w*DW +: DW];
          if (inject && int'(rd_idx[j*IW +: IW]) == fault_reg) v = v ^ 1'b1;
          rd_data[j*DW +: DW] <= v;
        end
      end
    end
  end

  always @(posedge clk) lk_q <= lock;

  // Monitor: one expected item per unlocked edge while busy; hold check on locked edges.
  always @(negedge clk) begin
    item_t act;
    act = {wr_data, wr_load, wr_idx, rd_load, rd_idx};
    if (busy && !rst) begin
      if (lk_q) begin
        chk(act == snap, "R9 outputs hold under lock", act, snap);
      end else if (exp_q.size() == 0) begin
        chk(1'b0, "R2 R3 cycle beyond schedule", act, '0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(act == e, "R4 R5 R6 per-cycle port values", act, e);
      end
    end
    snap = act;
  endtask_dummy: begin end
  end

  task automatic build_expect();
    int          wb = 0;
    int          rb = 0;
    logic [31:0] s = SEED;
    for (int c = 0; c < TOTAL; c++) begin
      item_t it = '0;
      if (c < FILL) begin
        for (int j = 0; j < NWR; j++) begin
          if (j < MAXWR && wb < NREG) begin
            s = lfsr_step(s);
            it.wd[j*DW +: DW] = s[DW-1:0];
            it.wl[j] = 1'b1;
            it.wi[j*IW +: IW] = IW'(wb);
            wb++;
          end
        end
      end
      if (c >= IGN - LAT) begin
        for (int j = 0; j < NRD; j++) begin
          it.rl[j] = 1'b1;
          it.ri[j*IW +: IW] = IW'((rb + j) % NREG);
        end
        rb = (rb + NRD) % NREG;
      end
      exp_q.push_back(it);
    end
  endtask

  task automatic run_once(input bit pulse_busy, input int lk_len, input bit flt,
                          input int freg, input bit exp_pass, input int exp_fc);
    int n = 0;
    inject = flt;
    fault_reg = freg;
    build_expect();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R2 busy after start", {busy, done}, 2'b10);
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      start = pulse_busy && (n == 1);
      lock  = (n >= 2 && n < 2 + lk_len);
    end
    start = 1'b0;
    lock  = 1'b0;
    chk(n == TOTAL + lk_len, "R3 edges from start to done", n, TOTAL + lk_len);
    chk(exp_q.size() == 0, "R3 whole schedule produced", exp_q.size(), 0);
    chk(busy == 1'b0, "R3 busy falls with done", busy, 0);
    chk(wr_load == '0 && rd_load == '0, "R4 R6 ports quiet after run", {wr_load, rd_load}, 0);
    chk(pass == exp_pass, "R8 pass flag", pass, exp_pass);
    chk(int'(fail_cycle) == exp_fc, "R7 R8 first failing cycle", fail_cycle, exp_fc);
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(done && pass == exp_pass && int'(fail_cycle) == exp_fc, "R8 results held",
        {done, pass, fail_cycle}, {1'b1, exp_pass, CW'(exp_fc)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_load == '0 && rd_load == '0 && wr_data == '0 && wr_idx == '0 && rd_idx == '0,
        "R1 ports in reset", {wr_load, rd_load, wr_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, pass, fail_cycle} == '0, "R1 status after reset", {busy, done, pass, fail_cycle}, 0);
    lock = 1'b1;
    start = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R9 start ignored under lock", busy, 0);
    lock = 1'b0;
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && wr_load == '0, "R2 idle without start", {busy, wr_load}, 0);
    // Clean run with a start pulse while busy (R2)
    run_once(1'b1, 0, 1'b0, 0, 1'b1, 0);
    // Run with a three-edge lock in the middle (R9)
    run_once(1'b0, 3, 1'b0, 0, 1'b1, 0);
    // Fault on a written register: first check of register 5 (R7)
    run_once(1'b0, 0, 1'b1, 5, 1'b0, IGN + 5 / NRD);
    // Fault on a never-written register, which must read 0 (R7), and start re-arms pass (R8)
    run_once(1'b0, 0, 1'b1, 7, 1'b0, IGN + 7 / NRD);
    // Clean run after a failed one: pass re-armed (R8)
    run_once(1'b0, 0, 1'b0, 0, 1'b1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule